// File: doc/BRIEF.md
# Inter-processor interrupt generator

This block lets any core on a multi-core chip interrupt any other core, or an external host, and leave a record of who called. Each target (every core, plus the host) owns a bank of 28 sticky source flags. Software sets flags and fires the interrupt through the target's generation register. The handler reads the flags and clears them through a second, aliased acknowledge register. Every core also has a non-maskable interrupt generation register that fires a pulse and holds no flags.

All accesses go through one synchronous register bus: a word address, a write enable, 32-bit write data and combinational read data. Every interrupt output is a registered pulse one clock wide. A second request that arrives while a lane is already pulsing is held and emitted after one low cycle. Interrupt controllers, bus bridges and clock-domain crossing sit outside this block.

Top module: `ipi_gen`

## Requirements
- R1: With N_CORES cores, the word addresses are: NMI registers at 0..N-1, core generation registers at N..2N-1, host generation at 2N, core acknowledge registers at 2N+1..3N, and host acknowledge at 3N+1. Every other address is unmapped.
- R2: A write with bit 0 set to a core's generation register raises `ipi_o` for that core alone. The pulse starts in the cycle after the write and lasts exactly one cycle.
- R3: In a generation register, bits 4..31 are source flags 0..27. Writing 1 to a flag sets it. Writing 0 leaves it unchanged. A write with bit 0 clear sets flags without producing a pulse. Flags hold their value when no write occurs.
- R4: A generation register and its acknowledge register both read the target's flags in bits 4..31. Bits 0..3 always read 0.
- R5: Writing 1 to a flag position of an acknowledge register clears that flag, and the cleared flag is seen through both views. Writing 0 has no effect.
- R6: A single generation write can set flags and fire the pulse at the same time.
- R7: A write with bit 0 set to a core's NMI register pulses `nmi_o` for that core for one cycle. A write with bit 0 clear does nothing. NMI registers read 0.
- R8: The host generation and acknowledge pair follows the rules of R3..R6. Its pulse appears on `host_irq_o`.
- R9: Two qualifying writes to one lane in consecutive cycles give two one-cycle pulses with one low cycle between them.
- R10: Reset (`rst_ni` low, asynchronous) clears every flag and holds every pulse output low.
- R11: Writes to unmapped addresses change no flag and raise no pulse. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the current address |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ipi_o | output | N_CORES | Inter-processor interrupt pulse per core |
| nmi_o | output | N_CORES | Non-maskable interrupt pulse per core |
| host_irq_o | output | 1 | Host interrupt pulse |

## Verification
The hardest case to reach is a lane that receives a new request while its pulse is still high. The request must be held rather than merged into a longer pulse. The stimulus reaches this case by issuing two generation writes to one core on consecutive clock edges, and then sampling the output after each of the next four edges to expect high, low, high, low. The aliasing between the two views is checked by setting flags through one address and reading and clearing them through the other. A reset is also applied while a pulse is high.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W  = 32;
  localparam int SRC_W   = 28;
  localparam int SRC_LSB = 4;
  localparam int FIRE_BIT = 0;
  localparam int IDX_W   = 8;

  typedef logic [SRC_W-1:0] src_t;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_NMI  = 2'd1,
    REG_GEN  = 2'd2,
    REG_ACK  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;

  function automatic int gen_base(int n);
    return n;
  endfunction

  function automatic int ack_base(int n);
    return 2 * n + 1;
  endfunction

  function automatic int map_words(int n);
    return 3 * n + 2;
  endfunction
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  localparam int GEN_LO = gen_base(N_CORES);
  localparam int ACK_LO = ack_base(N_CORES);
  localparam int END_W  = map_words(N_CORES);

  int a;
  assign a = int'(addr_i);

  always_comb begin
    sel_o.kind = REG_NONE;
    sel_o.idx  = '0;
    if (a < GEN_LO) begin
      sel_o.kind = REG_NMI;
      sel_o.idx  = IDX_W'(a);
    end else if (a < ACK_LO) begin
      sel_o.kind = REG_GEN;
      sel_o.idx  = IDX_W'(a - GEN_LO);
    end else if (a < END_W) begin
      sel_o.kind = REG_ACK;
      sel_o.idx  = IDX_W'(a - ACK_LO);
    end
  end
endmodule

// File: rtl/ipi_src_flags.sv
module ipi_src_flags
  import ipi_pkg::*;
#(
  parameter int N_TGT = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_TGT-1:0]            set_sel_i,
  input  logic [N_TGT-1:0]            clr_sel_i,
  input  src_t                        bits_i,
  output logic [N_TGT-1:0][SRC_W-1:0] flags_o
);
  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    src_t set_m, clr_m;
    assign set_m = set_sel_i[t] ? bits_i : '0;
    assign clr_m = clr_sel_i[t] ? bits_i : '0;

    // set applied after clear: set wins on overlap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[t] <= '0;
      else         flags_o[t] <= (flags_o[t] & ~clr_m) | set_m;
    end
  end
endmodule

// File: rtl/ipi_pulse_gen.sv
module ipi_pulse_gen #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] pulse_o
);
  for (genvar l = 0; l < WIDTH; l++) begin : g_lane
    logic pend_q, want;
    assign want = req_i[l] | pend_q;

    // a request during a high cycle is parked and fires after one low cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pulse_o[l] <= 1'b0;
        pend_q     <= 1'b0;
      end else begin
        pulse_o[l] <= want & ~pulse_o[l];
        pend_q     <= want & pulse_o[l];
      end
    end
  end
endmodule

// File: rtl/ipi_gen.sv
module ipi_gen
  import ipi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [N_CORES-1:0] ipi_o,
  output logic [N_CORES-1:0] nmi_o,
  output logic               host_irq_o
);
  localparam int N_TGT = N_CORES + 1;  // last target is the host

  reg_sel_t                    sel;
  logic [N_TGT-1:0]            set_sel, clr_sel, fire_req;
  logic [N_CORES-1:0]          nmi_req;
  logic [N_TGT-1:0]            tgt_pulse;
  logic [N_TGT-1:0][SRC_W-1:0] flags_q;
  src_t                        wbits;
  logic                        fire;

  assign wbits = wdata_i[SRC_LSB +: SRC_W];
  assign fire  = wdata_i[FIRE_BIT];

  ipi_addr_decode #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar t = 0; t < N_TGT; t++) begin : g_sel
    logic hit;
    assign hit         = wr_en_i && (sel.idx == IDX_W'(t));
    assign set_sel[t]  = hit && (sel.kind == REG_GEN);
    assign clr_sel[t]  = hit && (sel.kind == REG_ACK);
    assign fire_req[t] = set_sel[t] && fire;
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_nmi
    assign nmi_req[c] = wr_en_i && (sel.kind == REG_NMI) &&
                        (sel.idx == IDX_W'(c)) && fire;
  end

  ipi_src_flags #(.N_TGT(N_TGT)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_sel_i (set_sel),
    .clr_sel_i (clr_sel),
    .bits_i    (wbits),
    .flags_o   (flags_q)
  );

  ipi_pulse_gen #(.WIDTH(N_TGT)) u_tgt_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (fire_req),
    .pulse_o (tgt_pulse)
  );

  ipi_pulse_gen #(.WIDTH(N_CORES)) u_nmi_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (nmi_req),
    .pulse_o (nmi_o)
  );

  assign ipi_o      = tgt_pulse[N_CORES-1:0];
  assign host_irq_o = tgt_pulse[N_CORES];

  // both views of a target return the same flags; fire and reserved bits read 0
  always_comb begin
    rdata_o = '0;
    if (sel.kind == REG_GEN || sel.kind == REG_ACK) begin
      for (int t = 0; t < N_TGT; t++) begin
        if (sel.idx == IDX_W'(t)) rdata_o[SRC_LSB +: SRC_W] = flags_q[t];
      end
    end
  end
endmodule

// File: rtl/ipi_gen_checker.sv
module ipi_gen_checker
  import ipi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 5
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              wr_en_i,
  input logic [ADDR_W-1:0]                 addr_i,
  input logic [DATA_W-1:0]                 wdata_i,
  input logic [DATA_W-1:0]                 rdata_o,
  input logic [N_CORES-1:0]                ipi_o,
  input logic [N_CORES-1:0]                nmi_o,
  input logic                              host_irq_o,
  input logic [N_CORES:0][SRC_W-1:0]       flags
);
  localparam int N_TGT = N_CORES + 1;
  localparam int PW    = 2 * N_CORES + 1;

  logic [PW-1:0] pulses;
  assign pulses = {host_irq_o, nmi_o, ipi_o};

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulses & $past(pulses)) == '0); // R9

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[SRC_LSB-1:0] == '0); // R4

  AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(flags)); // R3

  AST_NMI_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o != '0) |-> ($past(wr_en_i) || $past(wr_en_i, 2))); // R7

  AST_HOST_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> ($past(wr_en_i) || $past(wr_en_i, 2))); // R8

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    AST_GEN_SETS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(gen_base(N_CORES) + t)) |=>
      ((flags[t] & $past(wdata_i[SRC_LSB +: SRC_W])) == $past(wdata_i[SRC_LSB +: SRC_W]))); // R3
    AST_ACK_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(ack_base(N_CORES) + t)) |=>
      ((flags[t] & $past(wdata_i[SRC_LSB +: SRC_W])) == '0)); // R5
  end
endmodule

bind ipi_gen ipi_gen_checker #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_ipi_gen_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ipi_o      (ipi_o),
  .nmi_o      (nmi_o),
  .host_irq_o (host_irq_o),
  .flags      (flags_q)
);

// File: tb/ipi_gen_bench.sv
module ipi_gen_bench;
  localparam int CLK_P  = 10;
  localparam int NC     = 4;
  localparam int AW     = 5;
  localparam int N_VEC  = 14;

  typedef struct packed {
    logic [AW-1:0] wa;
    logic [31:0]   wd;
    logic [AW-1:0] ra;
    logic [31:0]   er;
    logic [NC-1:0] ei;
    logic [NC-1:0] en;
    logic          eh;
    logic [3:0]    rq;
  } vec_t;

  // map with 4 cores (R1): NMI 0-3, gen 4-7, host gen 8, ack 9-12, host ack 13
  localparam vec_t VEC [N_VEC] = '{
    '{5'd5,  32'h0000_0041, 5'd10, 32'h0000_0040, 4'b0010, 4'b0000, 1'b0, 4'd6},  // R6 set+fire core1
    '{5'd5,  32'h8000_0000, 5'd5,  32'h8000_0040, 4'b0000, 4'b0000, 1'b0, 4'd3},  // R3 set w/o fire
    '{5'd5,  32'h0000_0000, 5'd5,  32'h8000_0040, 4'b0000, 4'b0000, 1'b0, 4'd3},  // R3 zeros ignored
    '{5'd10, 32'h0000_0040, 5'd5,  32'h8000_0000, 4'b0000, 4'b0000, 1'b0, 4'd5},  // R5 clear via ack
    '{5'd10, 32'h0000_0000, 5'd10, 32'h8000_0000, 4'b0000, 4'b0000, 1'b0, 4'd5},  // R5 zeros ignored
    '{5'd3,  32'h0000_0001, 5'd3,  32'h0000_0000, 4'b0000, 4'b1000, 1'b0, 4'd7},  // R7 NMI core3
    '{5'd8,  32'h0000_0011, 5'd13, 32'h0000_0010, 4'b0000, 4'b0000, 1'b1, 4'd8},  // R8 host fire
    '{5'd4,  32'h0000_000F, 5'd4,  32'h0000_0000, 4'b0001, 4'b0000, 1'b0, 4'd4},  // R4 reserved bits
    '{5'd20, 32'hFFFF_FFFF, 5'd20, 32'h0000_0000, 4'b0000, 4'b0000, 1'b0, 4'd11}, // R11 unmapped
    '{5'd13, 32'h0000_0010, 5'd8,  32'h0000_0000, 4'b0000, 4'b0000, 1'b0, 4'd8},  // R8 host clear
    '{5'd0,  32'h0000_0000, 5'd5,  32'h8000_0000, 4'b0000, 4'b0000, 1'b0, 4'd7},  // R7 no fire bit
    '{5'd7,  32'hFFFF_FFF1, 5'd12, 32'hFFFF_FFF0, 4'b1000, 4'b0000, 1'b0, 4'd2},  // R2 core3 all flags
    '{5'd12, 32'hFFFF_FFF0, 5'd7,  32'h0000_0000, 4'b0000, 4'b0000, 1'b0, 4'd5},  // R5 full clear
    '{5'd10, 32'h8000_0000, 5'd10, 32'h0000_0000, 4'b0000, 4'b0000, 1'b0, 4'd5}   // R5 last flag
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] ipi, nmi;
  logic          host;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  ipi_gen #(.N_CORES(NC), .ADDR_W(AW)) u_ipi_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .ipi_o      (ipi),
    .nmi_o      (nmi),
    .host_irq_o (host)
  );

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input int rq, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(rq, "read", rdata, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(10, "ipi in reset", 32'(ipi), 0);
    chk(10, "nmi in reset", 32'(nmi), 0);
    chk(10, "host in reset", 32'(host), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 4; a <= 13; a++) rd_chk(10, AW'(a), 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      chk(int'(VEC[i].rq), "ipi pulse", 32'(ipi), 32'(VEC[i].ei));
      chk(int'(VEC[i].rq), "nmi pulse", 32'(nmi), 32'(VEC[i].en));
      chk(int'(VEC[i].rq), "host pulse", 32'(host), 32'(VEC[i].eh));
      rd_chk(int'(VEC[i].rq), VEC[i].ra, VEC[i].er);
      @(negedge clk);
      // R2: pulse gone after one cycle
      chk(2, "pulses drop", 32'({host, nmi, ipi}), 0);
    end

    // R9: back-to-back generation writes to core2
    wr_en = 1'b1; addr = 5'd6; wdata = 32'h1;
    @(posedge clk);
    @(negedge clk);
    chk(9, "b2b first", 32'(ipi), 32'b0100);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    chk(9, "b2b gap", 32'(ipi), 32'b0000);
    @(negedge clk);
    chk(9, "b2b second", 32'(ipi), 32'b0100);
    @(negedge clk);
    chk(9, "b2b end", 32'(ipi), 32'b0000);

    // R9: back-to-back NMIs on core0
    wr_en = 1'b1; addr = 5'd0; wdata = 32'h1;
    @(posedge clk);
    @(negedge clk);
    chk(9, "nmi b2b first", 32'(nmi), 32'b0001);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    chk(9, "nmi b2b gap", 32'(nmi), 32'b0000);
    @(negedge clk);
    chk(9, "nmi b2b second", 32'(nmi), 32'b0001);

    // R10: reset during a pulse clears flags and output
    @(negedge clk);
    wr(5'd4, 32'h0000_0101);
    chk(2, "core0 fire", 32'(ipi), 32'b0001);
    rst_n = 1'b0;
    #1;
    chk(10, "pulse cut by reset", 32'(ipi), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(10, 5'd4, 32'h0);
    rd_chk(10, 5'd9, 32'h0);
    chk(10, "outputs after reset", 32'({host, nmi, ipi}), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule